// File: doc/BRIEF.md
# Microcontroller Port Configuration and Shared-Pin Controller

This block is the I/O side of a small microcontroller. It holds one configuration register and drives two ports. One port is an 8-bit general-purpose port; software chooses open-drain drive, which is the default, or push-pull drive for it. The other is a pair of pins shared with the crystal oscillator. These pins carry the oscillator by default. Software can hand them to a 2-bit open-drain port instead. The register also stores a 2-bit package pin-mapping code, which the rest of the chip decodes.

The CPU reaches the block over a plain register bus: an address, a write strobe, write data and combinational read data. A write to a port address loads that port's output latch. A read of a port address returns the pin level after it has passed a two-flop synchronizer. It never returns the latch. Power-on reset returns the whole block to its defaults. The general reset clears only the push-pull bit and leaves the other configuration fields as they were. In stop mode the CPU is halted. Port writes are then ignored and every pin keeps its drive. The oscillator is switched off, and shared pins that are in clock mode are driven low.

Top module: `iopc_top`

## Requirements
- R1: After power-on reset the configuration register reads 0x00. Every port pin is an input with its pull-up on, which means oe=0 and pu=1 on the 8-bit port. The shared pins are in clock mode with oe=0 and pu=0. The conflict flag is 0.
- R2: A general reset clears the push-pull bit and sets both port latches back to all ones. The shared-pin bit and the mapping field keep their values, and so does the conflict flag.
- R3: The configuration register sits at address 0x0E. Bit 3 selects GPIO use of the shared pins. Bit 2 selects push-pull on the 8-bit port. Bits [1:0] hold the mapping code: 00 default, 01 20-pin, 10 24-pin, 11 reserved, and all four codes are stored as written. Bits [7:4] read as 0.
- R4: In open-drain mode a latch bit of 0 drives its pin low (oe=1, out=0). A latch bit of 1 releases the pin (oe=0) with the pull-up on.
- R5: In push-pull mode every 8-bit port pin is driven (oe=1) with out equal to its latch bit, and the pull-ups are off.
- R6: A read of a port address (8-bit port at 0xA0, shared port at 0xC0, zero-extended) returns the pin level sampled two clocks earlier, not the latch value.
- R7: When the shared pins are in GPIO mode they act as an open-drain port driven by the 0xC0 latch. In clock mode they are neither driven nor pulled up.
- R8: While stop is high, port writes are ignored so the port drive holds, and osc_run is 0. Shared pins in clock mode are driven low (oe=11, out=00).
- R9: If the oscillator enable and the shared-pin GPIO bit are set together, the clock function wins and the shared pins get no GPIO drive. A conflict flag rises one clock later and stays set until power-on reset.
- R10: Writes to unmapped addresses change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_sys | input | 1 | General reset, synchronous, active high |
| stop_i | input | 1 | Stop mode |
| osc_en_i | input | 1 | Oscillator enable from the clock configuration register |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pa_in | input | 8 | 8-bit port pin levels |
| pa_oe | output | 8 | 8-bit port output enables |
| pa_out | output | 8 | 8-bit port output values |
| pa_pu | output | 8 | 8-bit port pull-up enables |
| pb_in | input | 2 | Shared pin levels |
| pb_oe | output | 2 | Shared pin output enables |
| pb_out | output | 2 | Shared pin output values |
| pb_pu | output | 2 | Shared pin pull-up enables |
| osc_run_o | output | 1 | Oscillator running |
| conflict_o | output | 1 | Sticky clock/GPIO conflict flag |

## Verification
The bench drives a pin level that differs from the latch. It then reads the port one clock and two clocks later. A design that returned the latch, or that used one synchronizer stage instead of two, returns the wrong value at one of those two points. A general reset is applied while every configuration field is set, so a design that cleared the whole register, or that kept the push-pull bit, shows the wrong register value on read-back. In stop mode the bench writes to a port and expects the drive to stay unchanged, and it expects the clock-mode shared pins to be driven low. It also sets the oscillator enable and the GPIO bit together. A design that gave the pins to GPIO drives them, and one that let the flag drop loses it once the clash is gone.

// File: rtl/iopc_pkg.sv
package iopc_pkg;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int PA_W = 8;
    localparam int PB_W = 2;

    localparam logic [AW-1:0] ADDR_CFG = 8'h0E;
    localparam logic [AW-1:0] ADDR_PA  = 8'hA0;
    localparam logic [AW-1:0] ADDR_PB  = 8'hC0;

    typedef enum logic [1:0] {
        MAP_DEFAULT = 2'b00,
        MAP_PIN20   = 2'b01,
        MAP_PIN24   = 2'b10,
        MAP_RSVD    = 2'b11
    } pin_map_e;

    typedef struct packed {
        logic     shared_gpio;
        logic     push_pull;
        pin_map_e pin_map;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {SEL_NONE, SEL_CFG, SEL_PA, SEL_PB} sel_e;

    function automatic sel_e decode_addr(logic [AW-1:0] a);
        if (a == ADDR_CFG)     return SEL_CFG;
        else if (a == ADDR_PA) return SEL_PA;
        else if (a == ADDR_PB) return SEL_PB;
        else                   return SEL_NONE;
    endfunction
endpackage

// File: rtl/iopc_cfg_reg.sv
module iopc_cfg_reg
    import iopc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_por,
    input  logic           rst_sys,
    input  logic           wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic           osc_en,
    output cfg_t           cfg_q,
    output logic           conflict_q
);
    always_ff @(posedge clk) begin
        if (rst_por) begin
            cfg_q <= '{shared_gpio: 1'b0, push_pull: 1'b0, pin_map: MAP_DEFAULT};
        end else if (rst_sys) begin
            cfg_q.push_pull <= 1'b0;
        end else if (wr_en) begin
            cfg_q <= cfg_t'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_por)
            conflict_q <= 1'b0;
        else if (osc_en && cfg_q.shared_gpio)
            conflict_q <= 1'b1;
    end

    assert_sysrst_partial_R2: assert property (@(posedge clk) disable iff (rst_por)
        rst_sys |=> (!cfg_q.push_pull && cfg_q.shared_gpio == $past(cfg_q.shared_gpio)
                     && cfg_q.pin_map == $past(cfg_q.pin_map)));

    assert_conflict_sticky_R9: assert property (@(posedge clk) disable iff (rst_por)
        conflict_q |=> conflict_q);
endmodule

// File: rtl/iopc_sync.sv
module iopc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            q      <= '1;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    assert_two_stage_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> q == $past(d, 2));
endmodule

// File: rtl/iopc_port_drv.sv
module iopc_port_drv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         stop,
    input  logic         push_pull,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] pu
);
    logic [W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '1;
        else if (wr_en && !stop)
            latch_q <= wr_data;
    end

    always_comb begin
        if (push_pull) begin
            oe  = '1;
            out = latch_q;
            pu  = '0;
        end else begin
            oe  = ~latch_q;
            out = '0;
            pu  = '1;
        end
    end

    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        stop |=> $stable(latch_q));

    assert_od_never_high_R4: assert property (@(posedge clk) disable iff (rst)
        !push_pull |-> ((oe & out) == '0));
endmodule

// File: rtl/iopc_top.sv
module iopc_top
    import iopc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_por,
    input  logic            rst_sys,
    input  logic            stop_i,
    input  logic            osc_en_i,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [PA_W-1:0] pa_in,
    output logic [PA_W-1:0] pa_oe,
    output logic [PA_W-1:0] pa_out,
    output logic [PA_W-1:0] pa_pu,
    input  logic [PB_W-1:0] pb_in,
    output logic [PB_W-1:0] pb_oe,
    output logic [PB_W-1:0] pb_out,
    output logic [PB_W-1:0] pb_pu,
    output logic            osc_run_o,
    output logic            conflict_o
);
    sel_e sel;
    cfg_t cfg;
    logic rst_any;
    logic wr_ok;
    logic clock_mode;
    logic [PA_W-1:0] pa_sync;
    logic [PB_W-1:0] pb_sync;
    logic [PB_W-1:0] pbd_oe, pbd_out, pbd_pu;

    assign sel     = decode_addr(bus_addr);
    assign rst_any = rst_por | rst_sys;
    assign wr_ok   = bus_we & ~stop_i;

    iopc_cfg_reg u_cfg (
        .clk       (clk),
        .rst_por   (rst_por),
        .rst_sys   (rst_sys),
        .wr_en     (wr_ok && sel == SEL_CFG),
        .wr_data   (bus_wdata[CFG_W-1:0]),
        .osc_en    (osc_en_i),
        .cfg_q     (cfg),
        .conflict_q(conflict_o)
    );

    iopc_sync #(.W(PA_W)) u_sync_a (.clk(clk), .rst(rst_any), .d(pa_in), .q(pa_sync));
    iopc_sync #(.W(PB_W)) u_sync_b (.clk(clk), .rst(rst_any), .d(pb_in), .q(pb_sync));

    iopc_port_drv #(.W(PA_W)) u_drv_a (
        .clk      (clk),
        .rst      (rst_any),
        .wr_en    (wr_ok && sel == SEL_PA),
        .wr_data  (bus_wdata[PA_W-1:0]),
        .stop     (stop_i),
        .push_pull(cfg.push_pull),
        .oe       (pa_oe),
        .out      (pa_out),
        .pu       (pa_pu)
    );

    iopc_port_drv #(.W(PB_W)) u_drv_b (
        .clk      (clk),
        .rst      (rst_any),
        .wr_en    (wr_ok && sel == SEL_PB),
        .wr_data  (bus_wdata[PB_W-1:0]),
        .stop     (stop_i),
        .push_pull(1'b0),
        .oe       (pbd_oe),
        .out      (pbd_out),
        .pu       (pbd_pu)
    );

    // Clock function takes the shared pins whenever the oscillator is enabled.
    assign clock_mode = ~cfg.shared_gpio | osc_en_i;
    assign osc_run_o  = osc_en_i & ~stop_i;

    always_comb begin
        if (clock_mode) begin
            pb_oe  = stop_i ? '1 : '0;
            pb_out = '0;
            pb_pu  = '0;
        end else begin
            pb_oe  = pbd_oe;
            pb_out = pbd_out;
            pb_pu  = pbd_pu;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CFG: bus_rdata = DW'(cfg);
            SEL_PA:  bus_rdata = DW'(pa_sync);
            SEL_PB:  bus_rdata = DW'(pb_sync);
            default: bus_rdata = '0;
        endcase
    end

    assert_clock_wins_R9: assert property (@(posedge clk) disable iff (rst_por)
        osc_en_i |-> (pb_pu == '0 && (stop_i || pb_oe == '0)));

    assert_stop_pins_low_R8: assert property (@(posedge clk) disable iff (rst_por)
        (stop_i && !cfg.shared_gpio) |-> (pb_oe == '1 && pb_out == '0 && !osc_run_o));

    assert_unused_bits_zero_R3: assert property (@(posedge clk) disable iff (rst_por)
        (sel == SEL_CFG) |-> (bus_rdata[DW-1:CFG_W] == '0));
endmodule

// File: tb/test_iopc_top.sv
module test_iopc_top;
    logic       clk = 1'b0;
    logic       rst_por = 1'b1, rst_sys = 1'b0, stop_i = 1'b0, osc_en_i = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'hFF, pa_oe, pa_out, pa_pu;
    logic [1:0] pb_in = 2'b11, pb_oe, pb_out, pb_pu;
    logic       osc_run_o, conflict_o;
    int         n_checks = 0, n_fail = 0;
    logic [7:0] rd;

    always #4 clk = ~clk;

    iopc_top i_iopc_top (
        .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys), .stop_i(stop_i),
        .osc_en_i(osc_en_i), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_oe(pa_oe), .pa_out(pa_out), .pa_pu(pa_pu),
        .pb_in(pb_in), .pb_oe(pb_oe), .pb_out(pb_out), .pb_pu(pb_pu),
        .osc_run_o(osc_run_o), .conflict_o(conflict_o)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic t_reset_state;
        bus_read(8'h0E, rd);
        check("R1", "cfg after por", rd, 8'h00);
        check("R1", "pa_oe", pa_oe, 8'h00);
        check("R1", "pa_pu", pa_pu, 8'hFF);
        check("R1", "pb_oe", pb_oe, 0);
        check("R1", "pb_pu", pb_pu, 0);
        check("R1", "conflict", conflict_o, 0);
    endtask

    task automatic t_cfg_fields;
        bus_write(8'h0E, 8'hFB);
        bus_read(8'h0E, rd);
        check("R3", "cfg upper bits zero, map 11 kept", rd, 8'h0B);
        bus_write(8'h0E, 8'h06);
        bus_read(8'h0E, rd);
        check("R3", "cfg push-pull + map 10", rd, 8'h06);
        bus_write(8'h0E, 8'h01);
        bus_read(8'h0E, rd);
        check("R3", "cfg map 01", rd, 8'h01);
    endtask

    task automatic t_open_drain;
        bus_write(8'h0E, 8'h00);
        bus_write(8'hA0, 8'h5A);
        check("R4", "od pa_oe", pa_oe, 8'hA5);
        check("R4", "od pa_out", pa_out, 8'h00);
        check("R4", "od pa_pu", pa_pu, 8'hFF);
    endtask

    task automatic t_push_pull;
        bus_write(8'h0E, 8'h04);
        check("R5", "pp pa_oe", pa_oe, 8'hFF);
        check("R5", "pp pa_out", pa_out, 8'h5A);
        check("R5", "pp pa_pu", pa_pu, 8'h00);
    endtask

    task automatic t_read_pin;
        pa_in = 8'h3C;
        @(negedge clk);
        bus_read(8'hA0, rd);
        check("R6", "pin read after 1 clk (old)", rd, 8'hFF);
        @(negedge clk);
        bus_read(8'hA0, rd);
        check("R6", "pin read after 2 clk (not latch)", rd, 8'h3C);
    endtask

    task automatic t_shared_gpio;
        bus_write(8'h0E, 8'h08);
        bus_write(8'hC0, 8'h02);
        check("R7", "gpio pb_oe", pb_oe, 2'b01);
        check("R7", "gpio pb_out", pb_out, 2'b00);
        check("R7", "gpio pb_pu", pb_pu, 2'b11);
        pb_in = 2'b10;
        @(negedge clk);
        @(negedge clk);
        bus_read(8'hC0, rd);
        check("R6", "shared pin read", rd, 8'h02);
        bus_write(8'h0E, 8'h00);
        check("R7", "clock mode pb_oe", pb_oe, 2'b00);
        check("R7", "clock mode pb_pu", pb_pu, 2'b00);
    endtask

    task automatic t_stop;
        bus_write(8'h0E, 8'h04);
        bus_write(8'hA0, 8'h5A);
        osc_en_i = 1'b1;
        #1 check("R8", "osc_run before stop", osc_run_o, 1);
        @(negedge clk);
        stop_i = 1'b1;
        #1;
        check("R8", "osc_run in stop", osc_run_o, 0);
        check("R8", "stop pb_oe", pb_oe, 2'b11);
        check("R8", "stop pb_out", pb_out, 2'b00);
        bus_write(8'hA0, 8'h00);
        check("R8", "stop holds pa_out", pa_out, 8'h5A);
        stop_i = 1'b0;
        osc_en_i = 1'b0;
        #1 check("R8", "pa_out after stop", pa_out, 8'h5A);
    endtask

    task automatic t_conflict;
        osc_en_i = 1'b1;
        bus_write(8'h0E, 8'h08);
        check("R9", "clock wins pb_oe", pb_oe, 2'b00);
        check("R9", "clock wins pb_pu", pb_pu, 2'b00);
        @(negedge clk);
        check("R9", "conflict raised", conflict_o, 1);
        osc_en_i = 1'b0;
        bus_write(8'h0E, 8'h00);
        @(negedge clk);
        check("R9", "conflict sticky", conflict_o, 1);
    endtask

    task automatic t_sys_reset;
        bus_write(8'h0E, 8'h0D);
        bus_write(8'hA0, 8'h00);
        @(negedge clk);
        rst_sys = 1'b1;
        @(negedge clk);
        rst_sys = 1'b0;
        bus_read(8'h0E, rd);
        check("R2", "cfg after sys reset", rd, 8'h09);
        check("R2", "pa_oe after sys reset", pa_oe, 8'h00);
        check("R2", "pa_pu after sys reset", pa_pu, 8'hFF);
        check("R2", "conflict kept", conflict_o, 1);
        @(negedge clk);
        rst_por = 1'b1;
        @(negedge clk);
        rst_por = 1'b0;
        bus_read(8'h0E, rd);
        check("R1", "cfg after second por", rd, 8'h00);
        check("R9", "conflict cleared by por", conflict_o, 0);
    endtask

    task automatic t_unmapped;
        bus_write(8'h0E, 8'h02);
        bus_write(8'h30, 8'h55);
        bus_read(8'h30, rd);
        check("R10", "unmapped read", rd, 8'h00);
        bus_read(8'h0E, rd);
        check("R10", "cfg untouched", rd, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_por = 1'b0;
        t_reset_state();
        t_cfg_fields();
        t_open_drain();
        t_push_pull();
        t_read_pin();
        t_shared_gpio();
        t_stop();
        t_conflict();
        t_sys_reset();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule